// File: doc/BRIEF.md
# Address Breakpoint Unit

This block watches the memory accesses of a processor pipeline and raises a debug exception when one of them touches an armed watch window. It has four watch slots. Each slot holds a target address and has an arming field, an access-kind filter and a window size. All of these settings sit in one control word, which is read and written through a small register port. The access stream arrives one access per cycle. Each access carries its address, its size and its kind (fetch, store or load). A hit produces a one-cycle exception pulse on the following cycle. A status word records which slots caused it.

Two more events share the exception path and the status word. The first is a single-step request from the core. The second is a lock-out mode that traps any register-port access before the access can take effect. A handler-entry strobe from the core releases the lock-out, so debug software can then reprogram the unit.

Top module: `hw_bkpt_unit`

## Requirements
- R1: After reset, every slot address, the control word and the status word read 0, and `dbg_exc_o` is low.
- R2: Register selects are 0 to 3 for slot addresses, 4 for control and 5 for status; other selects read 0. Control keeps only bits 7:0, bit 13 and bits 31:16, and every other bit reads 0 (a write of 0xFFFFDFFF reads back as 0xFFFF00FF).
- R3: Slot n can match only while control bit 2n or bit 2n+1 is set. Either bit alone is enough. The hardware never clears these bits.
- R4: Slot n's kind filter is control bits 17+4n:16+4n. Code 00 matches fetches only, 01 matches stores only, and 11 matches stores or loads. The `acc_kind_i` input uses 00 for fetch, 01 for store and 10 for load.
- R5: A slot whose kind filter is 10 never matches.
- R6: Slot n's size field is control bits 19+4n:18+4n, with 00 for 1 byte, 01 for 2, 11 for 4 and 10 for 8. The `acc_size_i` input is log2 of the access size in bytes (0 to 3). A slot matches when its address and the access address agree above the larger of the two sizes. This catches any overlap between aligned ranges.
- R7: A cycle with an event (a hit, a step or a trap) gives `dbg_exc_o` high for exactly the next cycle. A cycle with no event leaves it low on the next cycle.
- R8: On each event, status bits 3:0 are loaded with the set of slots that hit in that cycle, and bits that did not hit are cleared. Several bits may be set together.
- R9: `step_i` causes an event and sets status bit 14. That bit may appear together with hit bits.
- R10: While control bit 13 is set, every register-port access is trapped. A trapped write changes nothing, a trapped read returns 0, and the trap sets status bit 13 and raises the exception.
- R11: `handler_entry_i` clears control bit 13 at the next edge and leaves the slot enable bits unchanged.
- R12: The status word changes only on events. Register-port writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | ADDR_W | Access byte address |
| acc_size_i | input | 2 | log2 of access size in bytes |
| acc_kind_i | input | 2 | 00 fetch, 01 store, 10 load |
| step_i | input | 1 | Single-step event |
| handler_entry_i | input | 1 | Debug handler entered; releases lock-out |
| reg_req_i | input | 1 | Register port access |
| reg_we_i | input | 1 | Write when high, read when low |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | ADDR_W | Write data |
| reg_rdata_o | output | ADDR_W | Read data, combinational |
| dbg_exc_o | output | 1 | Debug exception pulse |

## Verification
The bench builds the unit with its defaults: a 32-bit address and four slots. With these values every control field of every slot exists. The 8-byte window and the overlap between a wide access and a narrow slot can then be exercised at real addresses. Two slots are armed over one range so that hits on several slots in the same cycle can be observed, and slot 3 is programmed with the unsupported kind code. The lock-out sequence is run end to end: arming, a trapped read, a trapped write, the handler strobe, and read-back of the untouched slot address.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned LOCK_BIT = 13;
  localparam int unsigned STEP_BIT = 14;
  localparam int unsigned KIND_LSB = 16;
  localparam int unsigned SIZE_LSB = 18;
  localparam int unsigned SLOT_STRIDE = 4;

  localparam logic [2:0] SEL_CTRL = 3'd4;
  localparam logic [2:0] SEL_STAT = 3'd5;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_STORE = 2'b01,
    KIND_LOAD  = 2'b10
  } acc_kind_e;

  // size field code -> log2 bytes (non-monotonic code)
  function automatic logic [1:0] size_code_lg2(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               reg_req_i,
  input  logic                               reg_we_i,
  input  logic [2:0]                         reg_sel_i,
  input  logic [ADDR_W-1:0]                  reg_wdata_i,
  input  logic                               handler_entry_i,
  input  logic [CTRL_W-1:0]                  status_i,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]   slot_addr_o,
  output logic [2*NUM_SLOTS-1:0]             en_o,
  output logic [NUM_SLOTS-1:0][1:0]          kind_o,
  output logic [NUM_SLOTS-1:0][1:0]          size_o,
  output logic                               lock_o,
  output logic                               trap_o,
  output logic [ADDR_W-1:0]                  reg_rdata_o
);
  logic wr_ok;
  logic [CTRL_W-1:0] ctrl_word;

  assign trap_o = reg_req_i & lock_o;
  assign wr_ok  = reg_req_i & reg_we_i & ~lock_o;

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_addr_o[n] <= '0;
        en_o[2*n +: 2] <= '0;
        kind_o[n]      <= '0;
        size_o[n]      <= '0;
      end else begin
        if (wr_ok && reg_sel_i == 3'(n)) slot_addr_o[n] <= reg_wdata_i;
        if (wr_ok && reg_sel_i == SEL_CTRL) begin
          en_o[2*n +: 2] <= reg_wdata_i[2*n +: 2];
          kind_o[n]      <= reg_wdata_i[KIND_LSB + SLOT_STRIDE*n +: 2];
          size_o[n]      <= reg_wdata_i[SIZE_LSB + SLOT_STRIDE*n +: 2];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_o <= 1'b0;
    else if (handler_entry_i) lock_o <= 1'b0;
    else if (wr_ok && reg_sel_i == SEL_CTRL) lock_o <= reg_wdata_i[LOCK_BIT];
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[LOCK_BIT] = lock_o;
    for (int n = 0; n < NUM_SLOTS; n++) begin
      ctrl_word[2*n +: 2] = en_o[2*n +: 2];
      ctrl_word[KIND_LSB + SLOT_STRIDE*n +: 2] = kind_o[n];
      ctrl_word[SIZE_LSB + SLOT_STRIDE*n +: 2] = size_o[n];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_req_i && !reg_we_i && !lock_o) begin
      if (reg_sel_i < 3'(NUM_SLOTS))  reg_rdata_o = slot_addr_o[reg_sel_i[1:0]];
      else if (reg_sel_i == SEL_CTRL) reg_rdata_o = ADDR_W'(ctrl_word);
      else if (reg_sel_i == SEL_STAT) reg_rdata_o = ADDR_W'(status_i);
    end
  end
endmodule

// File: rtl/bkpt_slot_match.sv
module bkpt_slot_match
  import bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              armed_i,
  input  logic [ADDR_W-1:0] slot_addr_i,
  input  logic [1:0]        kind_i,
  input  logic [1:0]        size_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_size_i,
  input  logic [1:0]        acc_kind_i,
  output logic              hit_o
);
  logic              kind_ok;
  logic [1:0]        slot_lg, lg;
  logic [ADDR_W-1:0] mask;

  always_comb begin
    case (kind_i)
      2'b00:   kind_ok = (acc_kind_i == KIND_FETCH);
      2'b01:   kind_ok = (acc_kind_i == KIND_STORE);
      2'b11:   kind_ok = (acc_kind_i == KIND_STORE) || (acc_kind_i == KIND_LOAD);
      default: kind_ok = 1'b0;
    endcase
  end

  assign slot_lg = size_code_lg2(size_i);
  assign lg      = (slot_lg > acc_size_i) ? slot_lg : acc_size_i;
  assign mask    = ~((ADDR_W'(1) << lg) - ADDR_W'(1));
  assign hit_o   = acc_valid_i & armed_i & kind_ok &
                   (((slot_addr_i ^ acc_addr_i) & mask) == '0);
endmodule

// File: rtl/bkpt_event.sv
module bkpt_event
  import bkpt_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] hit_i,
  input  logic                 step_i,
  input  logic                 trap_i,
  output logic                 event_o,
  output logic [CTRL_W-1:0]    status_o,
  output logic                 dbg_exc_o
);
  logic [NUM_SLOTS-1:0] hit_q;
  logic                 lock_q, step_q;

  assign event_o = (|hit_i) | step_i | trap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q     <= '0;
      lock_q    <= 1'b0;
      step_q    <= 1'b0;
      dbg_exc_o <= 1'b0;
    end else begin
      dbg_exc_o <= event_o;
      if (event_o) begin
        hit_q  <= hit_i;
        lock_q <= trap_i;
        step_q <= step_i;
      end
    end
  end

  always_comb begin
    status_o = '0;
    status_o[NUM_SLOTS-1:0] = hit_q;
    status_o[LOCK_BIT] = lock_q;
    status_o[STEP_BIT] = step_q;
  end
endmodule

// File: rtl/hw_bkpt_unit.sv
module hw_bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_size_i,
  input  logic [1:0]        acc_kind_i,
  input  logic              step_i,
  input  logic              handler_entry_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  output logic              dbg_exc_o
);
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
  logic [2*NUM_SLOTS-1:0]           en;
  logic [NUM_SLOTS-1:0][1:0]        kind, size;
  logic [NUM_SLOTS-1:0]             hit;
  logic                             lock, trap, evt;
  logic [CTRL_W-1:0]                status;

  bkpt_regs #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_regs (
    .clk_i, .rst_ni, .reg_req_i, .reg_we_i, .reg_sel_i, .reg_wdata_i,
    .handler_entry_i, .status_i(status), .slot_addr_o(slot_addr),
    .en_o(en), .kind_o(kind), .size_o(size), .lock_o(lock), .trap_o(trap),
    .reg_rdata_o
  );

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_match
    bkpt_slot_match #(.ADDR_W(ADDR_W)) u_match (
      .armed_i(|en[2*n +: 2]), .slot_addr_i(slot_addr[n]),
      .kind_i(kind[n]), .size_i(size[n]),
      .acc_valid_i, .acc_addr_i, .acc_size_i, .acc_kind_i,
      .hit_o(hit[n])
    );
  end

  bkpt_event #(.NUM_SLOTS(NUM_SLOTS)) u_event (
    .clk_i, .rst_ni, .hit_i(hit), .step_i, .trap_i(trap),
    .event_o(evt), .status_o(status), .dbg_exc_o
  );
endmodule

// File: rtl/hw_bkpt_unit_chk.sv
module hw_bkpt_unit_chk #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      reg_req_i,
  input logic                      handler_entry_i,
  input logic [2*NUM_SLOTS-1:0]    en_i,
  input logic [NUM_SLOTS-1:0][1:0] kind_i,
  input logic                      lock_i,
  input logic [NUM_SLOTS-1:0]      hit_i,
  input logic                      event_i,
  input logic [31:0]               status_i,
  input logic                      dbg_exc_i
);
  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    // R3
    disarmed_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[2*n +: 2] == 2'b00) |-> !hit_i[n]);
    // R5
    bad_kind_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kind_i[n] == 2'b10) |-> !hit_i[n]);
  end

  // R7
  exc_follows_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> dbg_exc_i);
  // R7
  exc_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !event_i |=> !dbg_exc_i);
  // R8
  exc_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_exc_i |-> (status_i[3:0] != 4'b0 || status_i[14:13] != 2'b0));
  // R10
  lock_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && lock_i) |=> (status_i[13] && dbg_exc_i));
  // R11
  handler_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handler_entry_i |=> !lock_i);
  // R12
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !event_i |=> $stable(status_i));
endmodule

bind hw_bkpt_unit hw_bkpt_unit_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_req_i(reg_req_i),
  .handler_entry_i(handler_entry_i), .en_i(en), .kind_i(kind),
  .lock_i(lock), .hit_i(hit), .event_i(evt), .status_i(status),
  .dbg_exc_i(dbg_exc_o)
);

// File: tb/hw_bkpt_unit_tb.sv
`timescale 1ns/1ps
module hw_bkpt_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [1:0]  acc_size_i = '0;
  logic [1:0]  acc_kind_i = '0;
  logic        step_i = 1'b0;
  logic        handler_entry_i = 1'b0;
  logic        reg_req_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        dbg_exc_o;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [1:0] FETCH = 2'b00, STORE = 2'b01, LOAD = 2'b10;

  always #2 clk_i = ~clk_i;

  hw_bkpt_unit u_dut (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk_i);
    reg_req_i = 1; reg_we_i = 1; reg_sel_i = sel; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_req_i = 0; reg_we_i = 0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk_i);
    reg_req_i = 1; reg_we_i = 0; reg_sel_i = sel;
    #1 d = reg_rdata_o;
    @(posedge clk_i); #1;
    reg_req_i = 0;
  endtask

  // exc sampled in the cycle after the access
  task automatic acc(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] k,
                     input logic st, output logic exc);
    @(negedge clk_i);
    acc_valid_i = 1; acc_addr_i = a; acc_size_i = sz; acc_kind_i = k; step_i = st;
    @(posedge clk_i); #1;
    acc_valid_i = 0; step_i = 0;
    exc = dbg_exc_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 exc", 32'(dbg_exc_o), 0);
    rd(3'd4, d); check("R1 ctrl", d, 0);
    rd(3'd5, d); check("R1 status", d, 0);
    rd(3'd2, d); check("R1 slot2", d, 0);
  endtask

  task automatic t_ctrl_mask();
    logic [31:0] d;
    wr(3'd4, 32'hFFFF_DFFF);
    rd(3'd4, d); check("R2 ctrl mask", d, 32'hFFFF_00FF);
    rd(3'd7, d); check("R2 unused select", d, 0);
    wr(3'd4, 0);
  endtask

  task automatic t_fetch();
    logic e; logic [31:0] d;
    wr(3'd0, 32'h1000); wr(3'd4, 32'h0000_0001);
    acc(32'h1000, 2'd0, FETCH, 0, e); check("R4 fetch hit", 32'(e), 1);
    @(posedge clk_i); #1 check("R7 single pulse", 32'(dbg_exc_o), 0);
    rd(3'd5, d); check("R8 status slot0", d, 32'h1);
    acc(32'h1001, 2'd0, FETCH, 0, e); check("R6 1B miss", 32'(e), 0);
    acc(32'h1000, 2'd0, LOAD, 0, e); check("R4 fetch-only ignores load", 32'(e), 0);
  endtask

  task automatic t_store();
    logic e; logic [31:0] d;
    wr(3'd1, 32'h2000); wr(3'd4, 32'h00D0_0008);
    acc(32'h2002, 2'd0, LOAD, 0, e); check("R4 store-only ignores load", 32'(e), 0);
    acc(32'h2003, 2'd0, STORE, 0, e); check("R6 4B store hit", 32'(e), 1);
    rd(3'd5, d); check("R8 status slot1", d, 32'h2);
    acc(32'h2004, 2'd0, STORE, 0, e); check("R6 4B edge miss", 32'(e), 0);
  endtask

  task automatic t_rw8();
    logic e; logic [31:0] d;
    wr(3'd2, 32'h3000); wr(3'd4, 32'h0B00_0010);
    acc(32'h3007, 2'd0, LOAD, 0, e); check("R6 8B load hit", 32'(e), 1);
    rd(3'd5, d); check("R8 status slot2", d, 32'h4);
    acc(32'h3000, 2'd0, FETCH, 0, e); check("R4 rw ignores fetch", 32'(e), 0);
    acc(32'h3008, 2'd0, STORE, 0, e); check("R6 8B edge miss", 32'(e), 0);
  endtask

  task automatic t_bad_kind();
    logic e;
    wr(3'd3, 32'h4000); wr(3'd4, 32'h2000_0040);
    acc(32'h4000, 2'd0, LOAD, 0, e);  check("R5 code10 load", 32'(e), 0);
    acc(32'h4000, 2'd0, STORE, 0, e); check("R5 code10 store", 32'(e), 0);
    acc(32'h4000, 2'd0, FETCH, 0, e); check("R5 code10 fetch", 32'(e), 0);
  endtask

  task automatic t_multi();
    logic e; logic [31:0] d;
    wr(3'd0, 32'h5000); wr(3'd1, 32'h5002); wr(3'd4, 32'h005F_0005);
    acc(32'h5002, 2'd1, STORE, 0, e); check("R8 two hits exc", 32'(e), 1);
    rd(3'd5, d); check("R8 two hits status", d, 32'h3);
    acc(32'h5002, 2'd0, LOAD, 0, e);
    rd(3'd5, d); check("R8 load clears slot1 bit", d, 32'h1);
    acc(32'h5000, 2'd3, STORE, 0, e);
    rd(3'd5, d); check("R6 8B access spans both", d, 32'h3);
  endtask

  task automatic t_wide_and_disarm();
    logic e;
    wr(3'd0, 32'h6005); wr(3'd4, 32'h0000_0002);
    acc(32'h6004, 2'd2, FETCH, 0, e); check("R3 global bit arms, wide fetch overlaps", 32'(e), 1);
    wr(3'd4, 0);
    acc(32'h6005, 2'd0, FETCH, 0, e); check("R3 disarmed no exc", 32'(e), 0);
  endtask

  task automatic t_step();
    logic e; logic [31:0] d;
    acc(32'h0, 2'd0, LOAD, 1, e); check("R9 step exc", 32'(e), 1);
    rd(3'd5, d); check("R9 step status", d, 32'h4000);
    wr(3'd0, 32'h7000); wr(3'd4, 32'h1);
    acc(32'h7000, 2'd0, FETCH, 1, e);
    rd(3'd5, d); check("R9 step with hit", d, 32'h4001);
  endtask

  task automatic t_status_ro();
    logic [31:0] d;
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); check("R12 status write ignored", d, 32'h4001);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(3'd0, 32'h1000); wr(3'd4, 32'h0000_2001);
    rd(3'd0, d); check("R10 trapped read zero", d, 0);
    check("R10 trap exc on read", 32'(dbg_exc_o), 1);
    wr(3'd0, 32'h9999);
    check("R10 trap exc on write", 32'(dbg_exc_o), 1);
    @(negedge clk_i); handler_entry_i = 1;
    @(negedge clk_i); handler_entry_i = 0;
    rd(3'd4, d); check("R11 unlock keeps enable", d, 32'h1);
    rd(3'd5, d); check("R10 status trap bit", d, 32'h2000);
    rd(3'd0, d); check("R10 trapped write had no effect", d, 32'h1000);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    t_reset();
    t_ctrl_mask();
    t_fetch();
    t_store();
    t_rw8();
    t_bad_kind();
    t_multi();
    t_wide_and_disarm();
    t_step();
    t_status_ro();
    t_lock();
    repeat (2) @(posedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule